// File: doc/BRIEF.md
# Bit-band alias access bridge

This block is a bus slave that sits behind a 32 MiB alias window. Every 4-byte word in the window stands for a single bit of an underlying memory region. A read of an alias word turns into one downstream read, and the bridge returns the chosen bit. A write of an alias word turns into a locked read-modify-write of the containing unit. Only the chosen bit is changed, and the unit goes back at the same address and size. An error from either downstream phase is passed back to the requester.

The upstream port takes one request at a time. It carries a full address, a size code, write data and a write flag, and it answers with a one-cycle response that holds read data and an error flag. The downstream port holds valid until the memory pulses `dn_done`, which returns read data and an error flag with it. The parameter `REGION` selects the region pair. With REGION=0, source base 0x20000000 is paired with alias base 0x22000000. With REGION=1, 0x40000000 is paired with 0x42000000.

The controller has four states:
- IDLE accepts a request. A legal size goes to FETCH and an illegal size goes straight to REPLY.
- FETCH waits for the downstream read. It goes to STORE for a write with no error, and to REPLY for a read or after an error.
- STORE waits for the write-back, then goes to REPLY.
- REPLY drives the response for one cycle and returns to IDLE.

Top module: `bitband_bridge`

## Requirements
- R1: The downstream byte address is the source base ORed with ((request address − alias base) bits 24:0) shifted right by 5. With the default parameters, source base is 0x20000000 and alias base is 0x22000000.
- R2: The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. The downstream address is rounded down to a multiple of that size, and `dn_size` carries the same code.
- R3: Size code 3 is illegal. It returns a response with `rsp_err`=1 and issues no downstream access.
- R4: Let off be the alias offset. The bit index is off[6:2] masked with (8×bytes−1), and it selects bit 8k+j of `dn_rdata`/`dn_wdata`. Byte k of the unit sits in bits 8k+7:8k, and byte 0 is at the lowest address. The bit hit is therefore bit off[4:2] of memory byte (source base | off>>5).
- R5: A read returns the selected bit in `rsp_rdata[0]` with all other bits zero and `rsp_err`=0.
- R6: A write reads the unit first. It then writes it back at the same address and size with only the selected bit changed: the bit is set when `req_wdata[0]`=1 and cleared otherwise.
- R7: A downstream read error produces no write-back and returns `rsp_err`=1.
- R8: A write-back error returns `rsp_err`=1.
- R9: For a write, `dn_lock` is high during both the read and the write-back phases.
- R10: `rsp_valid` is a one-cycle pulse. `req_ready` is high only in IDLE, and after reset the bridge sits in IDLE with no downstream request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Alias address |
| req_size | input | 2 | Size code (0/1/2; 3 illegal) |
| req_wdata | input | 32 | Write data; bit 0 is the new bit value |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read result, bit 0 only |
| rsp_err | output | 1 | Error response |
| dn_valid | output | 1 | Downstream request |
| dn_write | output | 1 | Downstream write |
| dn_lock | output | 1 | Downstream held across the RMW |
| dn_addr | output | 32 | Aligned downstream byte address |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | 32 | Write-back unit |
| dn_done | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read unit |
| dn_err | input | 1 | Downstream error |

## Verification
Two decisions can fall in the same clock edge: FETCH seeing the downstream completion with its error flag, and the same edge deciding whether a write moves to STORE. The bench injects a read error while the request is a write. It judges the outcome by three things: no downstream write is counted, the memory image is unchanged, and the response carries the error. A second scenario lets the read succeed but fails the write-back, which checks that an error arriving in STORE also reaches the requester.

// File: rtl/bb_pkg.sv
package bb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_REPLY = 2'd3
    } state_e;

    localparam int WIN_BITS = 25;

    function automatic logic [31:0] src_base(input int region);
        return (region == 1) ? 32'h4000_0000 : 32'h2000_0000;
    endfunction

    function automatic logic [31:0] alias_base(input int region);
        return (region == 1) ? 32'h4200_0000 : 32'h2200_0000;
    endfunction
endpackage

// File: rtl/bb_addr_xlate.sv
module bb_addr_xlate #(
    parameter logic [31:0] SRC_BASE   = 32'h2000_0000,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
    parameter int          WIN_BITS   = 25
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    output logic [31:0] unit_addr,
    output logic [4:0]  bit_idx,
    output logic        size_ok
);
    logic [31:0]         diff;
    logic [WIN_BITS-1:0] off;
    logic [31:0]         byte_addr;
    logic                unused_bits;

    assign diff        = addr - ALIAS_BASE;
    assign off         = diff[WIN_BITS-1:0];
    assign byte_addr   = SRC_BASE | 32'(off[WIN_BITS-1:5]);
    assign unused_bits = ^{diff[31:WIN_BITS], off[1:0]};

    always_comb begin
        unique case (size)
            2'd0: begin unit_addr = byte_addr;                 bit_idx = {2'b00, off[4:2]}; size_ok = 1'b1; end
            2'd1: begin unit_addr = {byte_addr[31:1], 1'b0};   bit_idx = {1'b0, off[5:2]};  size_ok = 1'b1; end
            2'd2: begin unit_addr = {byte_addr[31:2], 2'b00};  bit_idx = off[6:2];          size_ok = 1'b1; end
            default: begin unit_addr = byte_addr;              bit_idx = 5'd0;              size_ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
    parameter int DW = 32,
    localparam int IW = $clog2(DW)
) (
    input  logic [DW-1:0] unit,
    input  logic [IW-1:0] idx,
    input  logic          set_val,
    output logic          bit_out,
    output logic [DW-1:0] merged
);
    logic [DW-1:0] mask;

    assign mask    = DW'(1) << idx;
    assign bit_out = unit[idx];
    assign merged  = set_val ? (unit | mask) : (unit & ~mask);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
    parameter int REGION = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        dn_valid,
    output logic        dn_write,
    output logic        dn_lock,
    output logic [31:0] dn_addr,
    output logic [1:0]  dn_size,
    output logic [31:0] dn_wdata,
    input  logic        dn_done,
    input  logic [31:0] dn_rdata,
    input  logic        dn_err
);
    import bb_pkg::*;

    localparam logic [31:0] SRC_B   = src_base(REGION);
    localparam logic [31:0] ALIAS_B = alias_base(REGION);

    state_e      state;
    logic        op_write, op_val, err_q, bit_q;
    logic [31:0] op_addr, wb_data;
    logic [1:0]  op_size;
    logic [4:0]  op_idx;

    logic [31:0] x_addr;
    logic [4:0]  x_idx;
    logic        x_ok;
    logic        m_bit;
    logic [31:0] m_unit;
    logic        unused_wd;

    assign unused_wd = ^req_wdata[31:1];

    bb_addr_xlate #(.SRC_BASE(SRC_B), .ALIAS_BASE(ALIAS_B), .WIN_BITS(WIN_BITS)) u_xlate (
        .addr(req_addr), .size(req_size),
        .unit_addr(x_addr), .bit_idx(x_idx), .size_ok(x_ok)
    );

    bb_bit_merge #(.DW(32)) u_merge (
        .unit(dn_rdata), .idx(op_idx), .set_val(op_val),
        .bit_out(m_bit), .merged(m_unit)
    );

    // state register and operation capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_write <= 1'b0;
            op_val   <= 1'b0;
            op_addr  <= '0;
            op_size  <= '0;
            op_idx   <= '0;
            wb_data  <= '0;
            err_q    <= 1'b0;
            bit_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    op_write <= req_write;
                    op_val   <= req_wdata[0];
                    op_addr  <= x_addr;
                    op_size  <= req_size;
                    op_idx   <= x_idx;
                    bit_q    <= 1'b0;
                    err_q    <= !x_ok;
                    state    <= x_ok ? ST_FETCH : ST_REPLY;
                end
                ST_FETCH: if (dn_done) begin
                    if (dn_err) begin
                        err_q <= 1'b1;
                        state <= ST_REPLY;
                    end else if (op_write) begin
                        wb_data <= m_unit;
                        state   <= ST_STORE;
                    end else begin
                        bit_q <= m_bit;
                        err_q <= 1'b0;
                        state <= ST_REPLY;
                    end
                end
                ST_STORE: if (dn_done) begin
                    err_q <= dn_err;
                    state <= ST_REPLY;
                end
                ST_REPLY: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        dn_valid  = (state == ST_FETCH) || (state == ST_STORE);
        dn_write  = (state == ST_STORE);
        dn_lock   = dn_valid && op_write;
        dn_addr   = op_addr;
        dn_size   = op_size;
        dn_wdata  = (state == ST_STORE) ? wb_data : 32'd0;
        rsp_valid = (state == ST_REPLY);
        rsp_err   = rsp_valid && err_q;
        rsp_rdata = {31'd0, rsp_valid && bit_q};
    end

    // R2: aligned downstream address for each size
    p_align_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_size == 2'd1) |-> (dn_addr[0] == 1'b0));
    p_align_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_size == 2'd2) |-> (dn_addr[1:0] == 2'b00));
    // R3: illegal size answered with error
    p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size == 2'd3) |=> (rsp_valid && rsp_err && !dn_valid));
    // R5: only bit 0 may be set in read data
    p_rd_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[31:1] == 31'd0));
    // R7: read error goes to reply, never to write-back
    p_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && dn_done && dn_err) |=> (rsp_valid && rsp_err && !dn_write));
    // R9: write-back always under lock
    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_write) |-> dn_lock);
    // R10: single-cycle response
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
endmodule

// File: tb/sim_bitband_bridge.sv
module sim_bitband_bridge;
    localparam logic [31:0] SRC   = 32'h2000_0000;
    localparam logic [31:0] ALIAS = 32'h2200_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        dn_valid, dn_write, dn_lock;
    logic [31:0] dn_addr, dn_wdata;
    logic [1:0]  dn_size;
    logic        dn_done = 1'b0, dn_err = 1'b0;
    logic [31:0] dn_rdata = '0;

    bitband_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_lock(dn_lock),
        .dn_addr(dn_addr), .dn_size(dn_size), .dn_wdata(dn_wdata),
        .dn_done(dn_done), .dn_rdata(dn_rdata), .dn_err(dn_err)
    );

    int checks = 0, fails = 0;
    logic [7:0] mem  [64];
    logic [7:0] snap [64];
    logic        inj_rd_err = 1'b0, inj_wr_err = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [1:0]  last_rd_size = '0, last_wr_size = '0;
    logic        last_rd_lock = 1'b0, last_wr_lock = 1'b0;

    // memory model: answers one negedge after a request appears
    always @(negedge clk) begin
        if (dn_valid && !dn_done) begin
            dn_done = 1'b1;
            if (dn_write) begin
                wr_cnt++;
                last_wr_addr = dn_addr; last_wr_size = dn_size; last_wr_lock = dn_lock;
                dn_err = inj_wr_err;
                if (!inj_wr_err)
                    for (int k = 0; k < (1 << dn_size); k++)
                        mem[(dn_addr[5:0] + k) & 63] = dn_wdata[8*k +: 8];
                dn_rdata = '0;
            end else begin
                rd_cnt++;
                last_rd_addr = dn_addr; last_rd_size = dn_size; last_rd_lock = dn_lock;
                dn_err = inj_rd_err;
                dn_rdata = '0;
                for (int k = 0; k < (1 << dn_size); k++)
                    dn_rdata[8*k +: 8] = mem[(dn_addr[5:0] + k) & 63];
            end
        end else begin
            dn_done = 1'b0;
            dn_err  = 1'b0;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] off, input logic [1:0] sz,
                          input logic val, output logic err, output logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ALIAS + off;
        req_size = sz; req_wdata = {31'h5555_5555, val};
        @(negedge clk);
        req_valid = 1'b0;
        err = 1'b1; data = 32'hDEAD_BEEF;
        for (int n = 0; n < 40; n++) begin
            if (rsp_valid) begin
                err = rsp_err; data = rsp_rdata;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + seed) ^ 8'h5A;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && dn_valid === 1'b0, "R10 reset idle",
            {29'd0, req_ready, rsp_valid, dn_valid}, 32'h4);
    endtask

    // R1 R2 R4 R5 R6 R9: every bit of every size, including unaligned byte positions
    task automatic t_sweep;
        logic err; logic [31:0] d; logic [31:0] off, exp_byte, exp_al;
        int idx, bitp, wr0, bad;
        logic newv;
        for (int sz = 0; sz < 3; sz++) begin
            for (int b = 0; b < (8 << sz); b++) begin
                fill(sz * 11 + b);
                off      = ((32'd8 + 32'(b >> 3)) << 5) | (32'(b & 7) << 2);
                exp_byte = SRC | (off >> 5);
                exp_al   = exp_byte & ~32'((1 << sz) - 1);
                idx      = int'(exp_byte[5:0]);
                bitp     = b & 7;
                newv     = ~mem[idx][bitp];
                for (int i = 0; i < 64; i++) snap[i] = mem[i];
                snap[idx][bitp] = newv;
                wr0 = wr_cnt;
                access(1'b1, off, 2'(sz), newv, err, d);
                chk(err == 1'b0, "R6 write ok", {31'd0, err}, 32'd0);
                chk(last_rd_addr == exp_al && last_rd_size == 2'(sz), "R1 R2 read address",
                    last_rd_addr, exp_al);
                chk(wr_cnt == wr0 + 1 && last_wr_addr == exp_al && last_wr_size == 2'(sz),
                    "R6 write-back address", last_wr_addr, exp_al);
                chk(last_rd_lock && last_wr_lock, "R9 lock both phases",
                    {30'd0, last_rd_lock, last_wr_lock}, 32'd3);
                bad = 0;
                for (int i = 0; i < 64; i++) if (mem[i] !== snap[i]) bad++;
                chk(bad == 0, "R4 R6 only selected bit changed", 32'(bad), 32'd0);
                access(1'b0, off, 2'(sz), 1'b0, err, d);
                chk(err == 1'b0 && d == {31'd0, newv}, "R5 read bit", d, {31'd0, newv});
            end
        end
    endtask

    task automatic t_high_offset;
        logic err; logic [31:0] d;
        fill(3);
        access(1'b0, 32'h01FF_FFFC, 2'd2, 1'b0, err, d);
        chk(last_rd_addr == 32'h200F_FFFC, "R1 top of window", last_rd_addr, 32'h200F_FFFC);
        chk(!last_rd_lock, "R9 read not locked", {31'd0, last_rd_lock}, 32'd0);
        chk(d == {31'd0, mem[63][7]}, "R5 top bit", d, {31'd0, mem[63][7]});
    endtask

    task automatic t_bad_size;
        logic err; logic [31:0] d; int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        access(1'b1, 32'h40, 2'd3, 1'b1, err, d);
        chk(err == 1'b1, "R3 illegal size error", {31'd0, err}, 32'd1);
        chk(rd_cnt == r0 && wr_cnt == w0, "R3 no downstream access", 32'(rd_cnt - r0 + wr_cnt - w0), 32'd0);
    endtask

    task automatic t_read_err;
        logic err; logic [31:0] d; int w0, bad;
        fill(9);
        for (int i = 0; i < 64; i++) snap[i] = mem[i];
        inj_rd_err = 1'b1;
        access(1'b0, 32'h104, 2'd0, 1'b0, err, d);
        chk(err == 1'b1, "R7 read error on read", {31'd0, err}, 32'd1);
        w0 = wr_cnt;
        access(1'b1, 32'h104, 2'd1, ~mem[8][1], err, d);
        inj_rd_err = 1'b0;
        chk(err == 1'b1, "R7 read error on write", {31'd0, err}, 32'd1);
        chk(wr_cnt == w0, "R7 no write-back", 32'(wr_cnt - w0), 32'd0);
        bad = 0;
        for (int i = 0; i < 64; i++) if (mem[i] !== snap[i]) bad++;
        chk(bad == 0, "R7 memory unchanged", 32'(bad), 32'd0);
    endtask

    task automatic t_write_err;
        logic err; logic [31:0] d; int w0;
        fill(5);
        w0 = wr_cnt;
        inj_wr_err = 1'b1;
        access(1'b1, 32'h208, 2'd2, 1'b1, err, d);
        inj_wr_err = 1'b0;
        chk(err == 1'b1 && wr_cnt == w0 + 1, "R8 write-back error returned", {31'd0, err}, 32'd1);
    endtask

    task automatic t_pulse;
        logic err; logic [31:0] d;
        access(1'b0, 32'h20, 2'd0, 1'b0, err, d);
        chk(err == 1'b0, "R10 response seen", {31'd0, err}, 32'd0);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 one-cycle pulse",
            {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sweep();
        t_high_offset();
        t_bad_size();
        t_read_err();
        t_write_err();
        t_pulse();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule